// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block is a bus master for a two-wire serial bus (I2C). Software drives it through a small register port: a control register holds five single-shot request bits (Start, Repeated Start, Stop, byte receive and acknowledge-send), a data address launches a byte transmit on write and returns the last received byte on read, and a divider register sets the bus speed. The engine carries out one bus action at a time on open-drain SCL and SDA. When the action ends, it clears the request bit and raises a one-cycle interrupt.

While an action is running, any write that tries to start another one is dropped. There is no queue and no error flag. Software waits for the interrupt, or for `busy` to fall, before it issues the next request. The acknowledge level to send after a received byte and the acknowledge level returned by the slave after a transmitted byte are both held as control register bits. Both lines are only ever pulled low. SDA is sensed through an input that reads 1 when the line is released.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, the control register reads 0x00, `busy` and `irq` are 0, both line enables are 0 (released), and the divider (address 2) reads its reset value 3.
- R2: Writing control bit 0 while idle pulls SDA low while SCL is high, then pulls SCL low. Bit 0 reads 1 during the action and 0 once it is over.
- R3: Writing control bit 2 while idle pulls SDA low, releases SCL, then releases SDA while SCL is high (a Stop). Both lines end released and bit 2 clears itself.
- R4: Writing control bit 1 while idle releases SDA and then SCL, pulls SDA low while SCL is high, and ends with SCL held low. No Stop appears on the bus.
- R5: A write to address 1 while idle sends the byte on eight SCL pulses, most significant bit first. SDA is then released for a ninth pulse, and the SDA level seen on that pulse is stored in control bit 6 (1 = no acknowledge).
- R6: Writing control bit 3 while idle clocks eight bits in from SDA, most significant bit first. The byte then reads back at address 1, and bit 3 clears itself.
- R7: Writing control bit 4 while idle gives one SCL pulse with SDA equal to control bit 5, where 0 means driven low (acknowledge) and 1 means released. The bit value is taken from the same write.
- R8: Every SCL high and low phase lasts D+1 system clocks, where D is the divider value and a divider of 0 acts as 1. During byte actions, SDA changes only when SCL has already been low for at least one cycle.
- R9: While `busy` is 1, writes that set command bits, writes to address 1 and writes to the divider are ignored. Nothing is started later as a result.
- R10: If a write while idle sets several command bits, only the lowest-numbered one runs and is stored; the others are dropped.
- R11: Writing control bit 3 to 0 during a receive stops it. SCL is left low, `busy` falls at once, no interrupt is raised, and bit 3 reads 0.
- R12: Each action that completes raises `irq` for exactly one cycle while `busy` is still 1. In the next cycle `busy` is 0 and the command bits read 0.
- R13: Control bits 7 and 5 can be written and read back at any time, and writing them without a command bit causes no bus activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 data, 2 divider |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| busy | output | 1 | A bus action is in progress |
| irq | output | 1 | One-cycle completion pulse |
| sda_in | input | 1 | Sensed SDA level, 1 when released |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The hardest case to reach from the ports is a rejected request that lands in the middle of a transfer. The bench writes a Stop request and a second data byte while a transmit is clocking out its bits. It then checks three things: the byte on the wire is still the first one, no Stop appears on the bus, and the engine stays idle for many cycles afterwards. The receive abort is also timed from outside. The bench counts SCL rising edges and clears the receive bit after the third one, so the abort arrives partway through the byte.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

    localparam int NCMD = 5;

    // control register bit positions (priority follows bit order)
    localparam int B_START  = 0;
    localparam int B_RSTART = 1;
    localparam int B_STOP   = 2;
    localparam int B_RCEN   = 3;
    localparam int B_ACKEN  = 4;
    localparam int B_ACKDT  = 5;
    localparam int B_ACKST  = 6;
    localparam int B_GCEN   = 7;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_DATA = 2'd1;
    localparam logic [1:0] ADDR_DIV  = 2'd2;

    typedef enum logic [2:0] {
        OP_NONE, OP_START, OP_RSTART, OP_STOP, OP_RX, OP_ACK, OP_TX
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_RUN, ST_DONE
    } st_e;

endpackage

// File: rtl/i2c_cmd_pick.sv
module i2c_cmd_pick
    import i2c_cmd_pkg::*;
(
    input  logic [NCMD-1:0] req,
    output logic [NCMD-1:0] grant,
    output op_e             op
);

    genvar i;
    for (i = 0; i < NCMD; i++) begin : g_pri
        if (i == 0) begin : g_first
            assign grant[i] = req[i];
        end else begin : g_rest
            assign grant[i] = req[i] & ~(|req[i-1:0]);
        end
    end

    always_comb begin
        op = OP_NONE;
        if (grant[B_START])       op = OP_START;
        else if (grant[B_RSTART]) op = OP_RSTART;
        else if (grant[B_STOP])   op = OP_STOP;
        else if (grant[B_RCEN])   op = OP_RX;
        else if (grant[B_ACKEN])  op = OP_ACK;
    end

endmodule

// File: rtl/i2c_cmd_baud.sv
module i2c_cmd_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim   = (div == '0) ? DIV_W'(1) : div;
        tick  = run && (cnt_q == lim);
        cnt_d = (!run || tick) ? '0 : cnt_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine
    import i2c_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       launch,
    input  op_e        op_in,
    input  logic [7:0] tx_byte,
    input  logic       ack_bit,
    input  logic       abort,
    input  logic       tick,
    input  logic       sda_in,
    output logic       run,
    output logic       busy,
    output logic       done,
    output logic       scl_low,
    output logic       sda_low,
    output logic       ack_valid,
    output logic       ack_nack,
    output logic [7:0] shift_out,
    output op_e        op_cur
);

    typedef struct packed {
        st_e        st;
        op_e        op;
        logic [4:0] step;
        logic [7:0] sh;
        logic       scl_low;
        logic       sda_low;
        logic       ackv;
        logic       ackn;
        logic       ackbit;
    } eng_s;

    eng_s d, q;
    logic       is_byte;
    logic [4:0] last_step;
    logic       bit_low;

    always_comb begin
        is_byte   = (q.op == OP_TX) || (q.op == OP_RX) || (q.op == OP_ACK);
        case (q.op)
            OP_TX:   last_step = 5'd17;
            OP_RX:   last_step = 5'd15;
            default: last_step = 5'd1;
        endcase
        case (q.op)
            OP_TX:   bit_low = (q.step[4:1] < 4'd8) ? ~q.sh[7] : 1'b0;
            OP_ACK:  bit_low = ~q.ackbit;
            default: bit_low = 1'b0;
        endcase
    end

    always_comb begin
        d      = q;
        d.ackv = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (launch) begin
                    d.st   = ST_RUN;
                    d.op   = op_in;
                    d.step = '0;
                    case (op_in)
                        OP_START:  d.sda_low = 1'b1;
                        OP_RSTART: d.sda_low = 1'b0;
                        OP_STOP:   d.sda_low = 1'b1;
                        OP_TX: begin
                            d.sh      = tx_byte;
                            d.scl_low = 1'b1;
                        end
                        OP_RX: begin
                            d.sh      = '0;
                            d.scl_low = 1'b1;
                        end
                        OP_ACK: begin
                            d.ackbit  = ack_bit;
                            d.scl_low = 1'b1;
                        end
                        default: d.st = ST_IDLE;
                    endcase
                end
            end
            ST_RUN: begin
                if (abort && q.op == OP_RX) begin
                    d.st      = ST_IDLE;
                    d.op      = OP_NONE;
                    d.scl_low = 1'b1;
                    d.sda_low = 1'b0;
                end else begin
                    // data bit goes out one cycle after SCL fell
                    if (is_byte && !q.step[0] && q.scl_low)
                        d.sda_low = bit_low;
                    if (tick) begin
                        d.step = q.step + 5'd1;
                        case (q.op)
                            OP_START: begin
                                if (q.step == 5'd0) d.scl_low = 1'b1;
                                else                d.st      = ST_DONE;
                            end
                            OP_RSTART: begin
                                case (q.step)
                                    5'd0:    d.scl_low = 1'b0;
                                    5'd1:    d.sda_low = 1'b1;
                                    5'd2:    d.scl_low = 1'b1;
                                    default: d.st      = ST_DONE;
                                endcase
                            end
                            OP_STOP: begin
                                case (q.step)
                                    5'd0:    d.scl_low = 1'b0;
                                    5'd1:    d.sda_low = 1'b0;
                                    default: d.st      = ST_DONE;
                                endcase
                            end
                            default: begin
                                if (!q.step[0]) begin
                                    d.scl_low = 1'b0;
                                end else begin
                                    d.scl_low = 1'b1;
                                    if (q.op == OP_TX) begin
                                        d.sh = {q.sh[6:0], 1'b0};
                                        if (q.step == last_step) begin
                                            d.ackv = 1'b1;
                                            d.ackn = sda_in;
                                        end
                                    end else if (q.op == OP_RX) begin
                                        d.sh = {q.sh[6:0], sda_in};
                                    end
                                    if (q.step == last_step) d.st = ST_DONE;
                                end
                            end
                        endcase
                    end
                end
            end
            ST_DONE: begin
                d.st      = ST_IDLE;
                d.op      = OP_NONE;
                d.sda_low = 1'b0;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, op: OP_NONE, step: '0, sh: '0,
                   scl_low: 1'b0, sda_low: 1'b0, ackv: 1'b0, ackn: 1'b0,
                   ackbit: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign run       = (q.st == ST_RUN);
    assign busy      = (q.st != ST_IDLE);
    assign done      = (q.st == ST_DONE);
    assign scl_low   = q.scl_low;
    assign sda_low   = q.sda_low;
    assign ack_valid = q.ackv;
    assign ack_nack  = q.ackn;
    assign shift_out = q.sh;
    assign op_cur    = q.op;

endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
    import i2c_cmd_pkg::*;
#(
    parameter int          DIV_W     = 8,
    parameter int unsigned DIV_RESET = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       busy,
    output logic       irq,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe
);

    typedef struct packed {
        logic             gcen;
        logic             ackst;
        logic             ackdt;
        logic [NCMD-1:0]  cmd;
        logic [DIV_W-1:0] div;
        logic [7:0]       rx;
    } regs_s;

    regs_s d, q;

    logic [NCMD-1:0] grant;
    op_e             pick_op;
    logic            wr_ctrl, wr_data, wr_div;
    logic            launch_cmd, launch_tx;
    logic            eng_launch, eng_abort;
    op_e             eng_op;
    logic            eng_run, eng_busy, eng_done, eng_tick;
    logic            ack_valid, ack_nack;
    logic [7:0]      shift_out;
    op_e             op_cur;
    logic [NCMD-1:0] cmd_bits;
    logic            byte_op;

    i2c_cmd_pick u_pick (
        .req   (reg_wdata[NCMD-1:0]),
        .grant (grant),
        .op    (pick_op)
    );

    i2c_cmd_baud #(.DIV_W(DIV_W)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (eng_run),
        .div   (q.div),
        .tick  (eng_tick)
    );

    i2c_cmd_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (eng_launch),
        .op_in     (eng_op),
        .tx_byte   (reg_wdata),
        .ack_bit   (reg_wdata[B_ACKDT]),
        .abort     (eng_abort),
        .tick      (eng_tick),
        .sda_in    (sda_in),
        .run       (eng_run),
        .busy      (eng_busy),
        .done      (eng_done),
        .scl_low   (scl_oe),
        .sda_low   (sda_oe),
        .ack_valid (ack_valid),
        .ack_nack  (ack_nack),
        .shift_out (shift_out),
        .op_cur    (op_cur)
    );

    assign wr_ctrl    = reg_wr && (reg_addr == ADDR_CTRL);
    assign wr_data    = reg_wr && (reg_addr == ADDR_DATA);
    assign wr_div     = reg_wr && (reg_addr == ADDR_DIV);
    assign launch_cmd = wr_ctrl && !eng_busy && (|grant);
    assign launch_tx  = wr_data && !eng_busy;
    assign eng_launch = launch_cmd || launch_tx;
    assign eng_op     = launch_cmd ? pick_op : OP_TX;
    assign eng_abort  = wr_ctrl && eng_busy && q.cmd[B_RCEN] && !reg_wdata[B_RCEN];

    always_comb begin
        d = q;
        if (wr_ctrl) begin
            d.gcen  = reg_wdata[B_GCEN];
            d.ackdt = reg_wdata[B_ACKDT];
        end
        if (launch_cmd)          d.cmd = grant;
        if (eng_abort)           d.cmd[B_RCEN] = 1'b0;
        if (wr_div && !eng_busy) d.div = reg_wdata[DIV_W-1:0];
        if (ack_valid)           d.ackst = ack_nack;
        if (eng_done) begin
            d.cmd = '0;
            if (op_cur == OP_RX) d.rx = shift_out;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{gcen: 1'b0, ackst: 1'b0, ackdt: 1'b0, cmd: '0,
                   div: DIV_W'(DIV_RESET), rx: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_CTRL: reg_rdata = {q.gcen, q.ackst, q.ackdt, q.cmd};
            ADDR_DATA: reg_rdata = q.rx;
            ADDR_DIV:  reg_rdata = 8'(q.div);
            default:   reg_rdata = '0;
        endcase
    end

    assign busy     = eng_busy;
    assign irq      = eng_done;
    assign cmd_bits = q.cmd;
    assign byte_op  = (op_cur == OP_TX) || (op_cur == OP_RX) || (op_cur == OP_ACK);

endmodule

// File: rtl/i2c_cmd_master_chk.sv
module i2c_cmd_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       irq,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic [4:0] cmd,
    input logic       byte_op
);

    // R12: completion pulse lasts one cycle
    p_irq_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R12: the engine is idle right after the pulse
    p_idle_after_irq_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> (!busy && cmd == 5'd0));

    // R12: the pulse falls inside the busy window
    p_irq_in_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> busy);

    // R10: never more than one command held
    p_single_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd));

    // R9: command bits only appear when the engine was idle
    p_cmd_from_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((|cmd) && !$past(|cmd)) |-> !$past(busy));

    // R8: during byte actions SDA moves only with SCL held low
    p_sda_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && byte_op && (sda_oe != $past(sda_oe)))
            |-> (scl_oe && $past(scl_oe)));

    // R8: an SCL phase never lasts a single cycle
    p_scl_phase_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (scl_oe != $past(scl_oe))) |=> ($stable(scl_oe) || !busy));

endmodule

bind i2c_cmd_master i2c_cmd_master_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .irq     (irq),
    .scl_oe  (scl_oe),
    .sda_oe  (sda_oe),
    .cmd     (cmd_bits),
    .byte_op (byte_op)
);

// File: tb/i2c_cmd_master_bench.sv
module i2c_cmd_master_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       busy, irq, scl_oe, sda_oe;
    logic       slave_pull = 1'b0;
    logic       scl_line, sda_line;

    int n_checks = 0;
    int n_fail   = 0;
    int irq_cnt = 0, start_cnt = 0, stop_cnt = 0, rise_cnt = 0;
    int hi_run = 0, last_hi = 0;
    logic [8:0] sh9 = '0;
    logic scl_prev = 1'b1, sda_prev = 1'b1;

    assign scl_line = ~scl_oe;
    assign sda_line = ~sda_oe & ~slave_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_cmd_master u_i2c_cmd_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .irq       (irq),
        .sda_in    (sda_line),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe)
    );

    // bus monitor
    always @(negedge clk) begin
        if (irq) irq_cnt++;
        if (scl_prev && scl_line && sda_prev && !sda_line) start_cnt++;
        if (scl_prev && scl_line && !sda_prev && sda_line) stop_cnt++;
        if (!scl_prev && scl_line) begin
            rise_cnt++;
            sh9 = {sh9[7:0], sda_line};
            hi_run = 1;
        end else if (scl_line) begin
            hi_run++;
        end
        if (scl_prev && !scl_line) last_hi = hi_run;
        scl_prev = scl_line;
        sda_prev = sda_line;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick1();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        tick1();
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        tick1();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_scl(input logic lvl);
        for (int k = 0; k < 400; k++) begin
            if (scl_line == lvl) break;
            tick1();
        end
    endtask

    task automatic wait_rise(input int target);
        for (int k = 0; k < 2000; k++) begin
            if (rise_cnt >= target) break;
            tick1();
        end
    endtask

    // R12: wait for the pulse, then engine must be idle
    task automatic wait_irq(input int base, input string req);
        logic [7:0] v;
        for (int k = 0; k < 2000; k++) begin
            if (irq_cnt > base) break;
            tick1();
        end
        tick1();
        chk({req, " R12 busy after done"}, busy, 0);
        rd(2'd0, v);
        chk({req, " R12 command bits cleared"}, v[4:0], 0);
        chk({req, " R12 single pulse"}, irq_cnt, base + 1);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(2'd0, v);
        chk("R1 control reset", v, 8'h00);
        rd(2'd2, v);
        chk("R1 divider reset", v, 3);
        chk("R1 busy reset", busy, 0);
        chk("R1 irq reset", irq, 0);
        chk("R1 scl released", scl_oe, 0);
        chk("R1 sda released", sda_oe, 0);
    endtask

    task automatic t_flags();
        logic [7:0] v;
        int b = start_cnt;
        int r = rise_cnt;
        wr(2'd0, 8'hA0);
        rd(2'd0, v);
        chk("R13 flag readback", v, 8'hA0);
        chk("R13 no busy", busy, 0);
        repeat (5) tick1();
        chk("R13 no bus edges", rise_cnt + start_cnt, r + b);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_start();
        logic [7:0] v;
        int b = start_cnt;
        int bi = irq_cnt;
        wr(2'd0, 8'h01);
        rd(2'd0, v);
        chk("R2 start bit held", v[0], 1);
        chk("R2 busy during start", busy, 1);
        wait_irq(bi, "R2");
        chk("R2 start condition", start_cnt, b + 1);
        chk("R2 scl held low", scl_oe, 1);
    endtask

    task automatic t_tx(input logic [7:0] data, input logic nack,
                        input int exp_hi, input logic inject);
        logic [7:0] v;
        int br = rise_cnt;
        int bi = irq_cnt;
        int bs = stop_cnt;
        wr(2'd1, data);
        if (inject) begin
            wr(2'd0, 8'h04);
            wr(2'd1, 8'hFF);
            wr(2'd2, 8'h07);
            rd(2'd0, v);
            chk("R9 command ignored while busy", v[4:0], 0);
        end
        wait_rise(br + 8);
        wait_scl(1'b0);
        slave_pull = ~nack;
        wait_irq(bi, "R5");
        slave_pull = 1'b0;
        chk("R5 byte on bus msb first", sh9[8:1], data);
        chk("R5 ninth pulse level", sh9[0], nack);
        rd(2'd0, v);
        chk("R5 ack status bit", v[6], nack);
        chk("R8 high phase length", last_hi, exp_hi);
        if (inject) begin
            repeat (40) tick1();
            chk("R9 nothing queued busy", busy, 0);
            chk("R9 nothing queued edges", rise_cnt, br + 9);
            chk("R9 no stop", stop_cnt, bs);
            rd(2'd2, v);
            chk("R9 divider write ignored", v, 2);
        end
    endtask

    task automatic t_prio();
        logic [7:0] v;
        int b = start_cnt;
        int bs = stop_cnt;
        int bi = irq_cnt;
        wr(2'd0, 8'h06);
        rd(2'd0, v);
        chk("R10 lowest bit wins", v[4:0], 5'h02);
        wait_irq(bi, "R10");
        chk("R4 repeated start condition", start_cnt, b + 1);
        chk("R10 no stop issued", stop_cnt, bs);
        chk("R4 scl held low", scl_oe, 1);
    endtask

    task automatic t_rx(input logic [7:0] data);
        logic [7:0] v;
        int br = rise_cnt;
        int bi = irq_cnt;
        wr(2'd0, 8'h08);
        for (int i = 7; i >= 0; i--) begin
            slave_pull = ~data[i];
            wait_rise(br + (8 - i));
            wait_scl(1'b0);
        end
        slave_pull = 1'b0;
        wait_irq(bi, "R6");
        rd(2'd1, v);
        chk("R6 received byte", v, data);
        chk("R6 eight pulses", rise_cnt, br + 8);
    endtask

    task automatic t_ack(input logic dt);
        logic [7:0] v;
        int br = rise_cnt;
        int bi = irq_cnt;
        wr(2'd0, dt ? 8'h30 : 8'h10);
        wait_irq(bi, "R7");
        chk("R7 one pulse", rise_cnt, br + 1);
        chk("R7 sda level on pulse", sh9[0], dt);
        rd(2'd0, v);
        chk("R13 ack data kept", v[5], dt);
    endtask

    task automatic t_abort();
        logic [7:0] v;
        int br = rise_cnt;
        int bi = irq_cnt;
        wr(2'd0, 8'h08);
        wait_rise(br + 3);
        wr(2'd0, 8'h00);
        chk("R11 busy drops", busy, 0);
        chk("R11 scl left low", scl_oe, 1);
        rd(2'd0, v);
        chk("R11 receive bit cleared", v[3], 0);
        br = rise_cnt;
        repeat (20) tick1();
        chk("R11 no interrupt", irq_cnt, bi);
        chk("R11 bus quiet", rise_cnt, br);
    endtask

    task automatic t_stop();
        int bs = stop_cnt;
        int bi = irq_cnt;
        wr(2'd0, 8'h04);
        wait_irq(bi, "R3");
        chk("R3 stop condition", stop_cnt, bs + 1);
        chk("R3 scl released", scl_oe, 0);
        chk("R3 sda released", sda_oe, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R12 watchdog expired: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks + 1, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        repeat (3) tick1();
        rst_n = 1'b1;
        tick1();
        t_reset();
        t_flags();
        wr(2'd2, 8'd2);
        rd(2'd2, v);
        chk("R8 divider write", v, 2);
        t_start();
        t_tx(8'hA5, 1'b0, 3, 1'b0);
        t_tx(8'h3C, 1'b1, 3, 1'b0);
        t_tx(8'hA5, 1'b0, 3, 1'b1);
        t_prio();
        t_rx(8'h96);
        t_ack(1'b1);
        t_rx(8'h4B);
        t_ack(1'b0);
        t_abort();
        t_stop();
        wr(2'd2, 8'd0);
        t_start();
        t_tx(8'h81, 1'b0, 2, 1'b0);
        t_stop();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule